// File: doc/BRIEF.md
# Locked IDE Configuration Register Window

This block sits between a host bus and the command block of one parallel-ATA port. In its normal, locked state every access that reaches the window is passed on unchanged to the drive taskfile, and read data comes back from the taskfile. A short key sequence switches the same offsets to control mode. The key is a pair of 16-bit reads followed by one byte write. In control mode the offsets no longer reach the drive. Instead they select a small set of registers that hold drive timing.

Software picks a device with a selector register and writes read-cycle and write-cycle timing into that device's staging slot. It then writes a commit code to a control register, and the staged values become the timing the port drives. The address-setup code is one field shared by both devices, so software must choose it to suit the slower of the two. A byte write of a closing key returns the window to taskfile decoding. A strap input tells software whether the bus clock is 33 MHz or 25 MHz.

Top module: `ide_cfg_window`

## Requirements
- R1: The window enters control mode only after three accesses with nothing in between. The first two are 16-bit reads of offset 1. The third is an 8-bit write of 0x03 to offset 2. `ctrl_mode` reads 1 from the clock edge that takes the write.
- R2: In locked mode, an access that is not the expected next step of the key sequence returns the sequence to its start. Examples are a byte read, a third read, a wrong value or a 16-bit write. Every locked access, including the key steps, is forwarded on the taskfile port, and its read data is the taskfile data.
- R3: In control mode no access is forwarded (`tf_valid` stays 0). Reads return the selected control register in bits 7:0, with zeros above.
- R4: In control mode, an 8-bit write of 0x83 to offset 2 returns the window to locked mode at the next edge. A 16-bit write of 0x83, or a byte write of any other value, to that offset leaves control mode in place.
- R5: Control index 6 is the selector register and reads back as written. Bit 0 chooses the device (0 or 1) whose staging slot indices 0 and 1 address. Bits 7:4 hold the shared address-setup code.
- R6: A write to index 0 stages the read-cycle timing of the selected device, and a write to index 1 stages its write-cycle timing. Reads of indices 0 and 1 return the staged value of the selected device.
- R7: Writing 0x85 to index 3 copies both devices' staged timings and the setup code into the active outputs at the next edge. Any other value written there is only stored (and reads back) and changes no output. The active outputs change at no other time. Device 0 uses bits 7:0 of `act_rd_timing` and `act_wr_timing`, and device 1 uses bits 15:8.
- R8: `clk_is_25` follows the `strap_clk25` pin one cycle later (0 = 33 MHz, 1 = 25 MHz). A read of index 5 returns that value in bit 0, and writes to index 5 are ignored.
- R9: In control mode, indices 2, 4 and 7 read as zero, and writes to them change no register or output.
- R10: After reset the window is locked. All active and staged timings are 0xFF, the active setup code is 0xF, and the selector register reads 0xF0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Host access in this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit |
| acc_offset | input | 3 | Command-block offset |
| acc_wdata | input | 16 | Host write data |
| acc_rdata | output | 16 | Host read data |
| tf_valid | output | 1 | Access forwarded to the taskfile |
| tf_write | output | 1 | Forwarded direction |
| tf_wide | output | 1 | Forwarded size |
| tf_offset | output | 3 | Forwarded offset |
| tf_wdata | output | 16 | Forwarded write data |
| tf_rdata | input | 16 | Taskfile read data |
| strap_clk25 | input | 1 | Bus clock strap, 1 = 25 MHz |
| ctrl_mode | output | 1 | 1 while the control registers are mapped |
| clk_is_25 | output | 1 | Registered strap value |
| act_rd_timing | output | 16 | Active read timing, device 1 in the upper byte |
| act_wr_timing | output | 16 | Active write timing, device 1 in the upper byte |
| act_addr_setup | output | 4 | Active shared address-setup code |

## Verification
On every cycle, the assertions check the following:
- Control mode is entered only from a completed key sequence.
- The closing write always locks the window.
- Nothing is forwarded to the taskfile while unlocked.
- The active timing outputs stay frozen except on a commit, and a commit happens only in control mode.

Only the directed scenarios can show the following:
- The sequence restarts on each kind of broken key.
- Staged values land in the slot the selector chose and read back from it.
- The exact committed values, with each device in its own byte lane.
- Unimplemented indices read zero and absorb writes.
- The strap value appears both on the pin and at index 5.

// File: rtl/ide_win_pkg.sv
package ide_win_pkg;
  localparam int BYTE_W = 8;
  localparam int OFS_W  = 3;
  localparam int SETUP_LSB = 4;
  localparam int SETUP_W   = 4;

  localparam logic [OFS_W-1:0] IDX_RD_TIM = 3'd0;
  localparam logic [OFS_W-1:0] IDX_WR_TIM = 3'd1;
  localparam logic [OFS_W-1:0] IDX_CTL    = 3'd3;
  localparam logic [OFS_W-1:0] IDX_STRAP  = 3'd5;
  localparam logic [OFS_W-1:0] IDX_SEL    = 3'd6;

  localparam logic [OFS_W-1:0] OFS_KEY_RD = 3'd1;
  localparam logic [OFS_W-1:0] OFS_KEY_WR = 3'd2;

  localparam logic [BYTE_W-1:0] KEY_OPEN   = 8'h03;
  localparam logic [BYTE_W-1:0] KEY_CLOSE  = 8'h83;
  localparam logic [BYTE_W-1:0] KEY_COMMIT = 8'h85;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_RD1, SEQ_RD2} seq_t;

  // True when the access is the step the key sequence expects from cur.
  function automatic logic key_step_ok(seq_t cur, logic wr, logic wide,
                                       logic [OFS_W-1:0] ofs, logic [BYTE_W-1:0] d);
    case (cur)
      SEQ_IDLE, SEQ_RD1: key_step_ok = !wr && wide && (ofs == OFS_KEY_RD);
      SEQ_RD2:           key_step_ok = wr && !wide && (ofs == OFS_KEY_WR) && (d == KEY_OPEN);
      default:           key_step_ok = 1'b0;
    endcase
  endfunction

  function automatic seq_t key_next(seq_t cur, logic ok);
    if (!ok) return SEQ_IDLE;
    case (cur)
      SEQ_IDLE: return SEQ_RD1;
      SEQ_RD1:  return SEQ_RD2;
      default:  return SEQ_IDLE;
    endcase
  endfunction

  function automatic logic is_close(logic wr, logic wide, logic [OFS_W-1:0] ofs,
                                    logic [BYTE_W-1:0] d);
    return wr && !wide && (ofs == OFS_KEY_WR) && (d == KEY_CLOSE);
  endfunction
endpackage

// File: rtl/ide_win_unlock.sv
module ide_win_unlock
  import ide_win_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic             acc_wide,
  input  logic [OFS_W-1:0] acc_offset,
  input  logic [BYTE_W-1:0] acc_byte,
  output logic             ctrl_mode,
  output logic             unlock_done,
  output logic             relock_hit
);
  seq_t seq_q;
  logic step_ok;

  assign step_ok     = key_step_ok(seq_q, acc_write, acc_wide, acc_offset, acc_byte);
  assign unlock_done = acc_valid && !ctrl_mode && (seq_q == SEQ_RD2) && step_ok;
  assign relock_hit  = acc_valid && ctrl_mode &&
                       is_close(acc_write, acc_wide, acc_offset, acc_byte);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_q     <= SEQ_IDLE;
      ctrl_mode <= 1'b0;
    end else if (acc_valid) begin
      if (ctrl_mode) begin
        if (relock_hit) ctrl_mode <= 1'b0;
      end else begin
        seq_q <= key_next(seq_q, step_ok);
        if (unlock_done) ctrl_mode <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ide_win_regs.sv
module ide_win_regs
  import ide_win_pkg::*;
#(
  parameter int NUM_DEV = 2,
  parameter logic [BYTE_W-1:0] TIM_DEF = 8'hFF,
  parameter logic [SETUP_W-1:0] SETUP_DEF = 4'hF
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [OFS_W-1:0]           idx,
  input  logic [BYTE_W-1:0]          wdata,
  input  logic                       strap_q,
  output logic [BYTE_W-1:0]          rdata,
  output logic                       commit_hit,
  output logic [NUM_DEV*BYTE_W-1:0]  act_rd,
  output logic [NUM_DEV*BYTE_W-1:0]  act_wr,
  output logic [SETUP_W-1:0]         act_setup
);
  localparam int SEL_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
  localparam logic [BYTE_W-1:0] SEL_DEF = BYTE_W'(SETUP_DEF) << SETUP_LSB;

  logic [BYTE_W-1:0] sel_q, ctl_q;
  logic [SEL_W-1:0]  dev_sel;
  logic [NUM_DEV*BYTE_W-1:0] st_rd, st_wr;

  assign dev_sel    = sel_q[SEL_W-1:0];
  assign commit_hit = wr_en && (idx == IDX_CTL) && (wdata == KEY_COMMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q     <= SEL_DEF;
      ctl_q     <= '0;
      act_setup <= SETUP_DEF;
    end else begin
      if (wr_en && idx == IDX_SEL) sel_q <= wdata;
      if (wr_en && idx == IDX_CTL) ctl_q <= wdata;
      if (commit_hit) act_setup <= sel_q[SETUP_LSB +: SETUP_W];
    end
  end

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    logic [BYTE_W-1:0] srd_q, swr_q, ard_q, awr_q;
    logic hit;
    assign hit = wr_en && (dev_sel == SEL_W'(d));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        srd_q <= TIM_DEF;
        swr_q <= TIM_DEF;
        ard_q <= TIM_DEF;
        awr_q <= TIM_DEF;
      end else begin
        if (hit && idx == IDX_RD_TIM) srd_q <= wdata;
        if (hit && idx == IDX_WR_TIM) swr_q <= wdata;
        if (commit_hit) begin
          ard_q <= srd_q;
          awr_q <= swr_q;
        end
      end
    end
    assign st_rd[d*BYTE_W +: BYTE_W]  = srd_q;
    assign st_wr[d*BYTE_W +: BYTE_W]  = swr_q;
    assign act_rd[d*BYTE_W +: BYTE_W] = ard_q;
    assign act_wr[d*BYTE_W +: BYTE_W] = awr_q;
  end

  always_comb begin
    case (idx)
      IDX_RD_TIM: rdata = st_rd[int'(dev_sel)*BYTE_W +: BYTE_W];
      IDX_WR_TIM: rdata = st_wr[int'(dev_sel)*BYTE_W +: BYTE_W];
      IDX_CTL:    rdata = ctl_q;
      IDX_STRAP:  rdata = {{(BYTE_W-1){1'b0}}, strap_q};
      IDX_SEL:    rdata = sel_q;
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/ide_cfg_window.sv
module ide_cfg_window
  import ide_win_pkg::*;
#(
  parameter int BUS_W   = 16,
  parameter int NUM_DEV = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      acc_valid,
  input  logic                      acc_write,
  input  logic                      acc_wide,
  input  logic [OFS_W-1:0]          acc_offset,
  input  logic [BUS_W-1:0]          acc_wdata,
  output logic [BUS_W-1:0]          acc_rdata,
  output logic                      tf_valid,
  output logic                      tf_write,
  output logic                      tf_wide,
  output logic [OFS_W-1:0]          tf_offset,
  output logic [BUS_W-1:0]          tf_wdata,
  input  logic [BUS_W-1:0]          tf_rdata,
  input  logic                      strap_clk25,
  output logic                      ctrl_mode,
  output logic                      clk_is_25,
  output logic [NUM_DEV*BYTE_W-1:0] act_rd_timing,
  output logic [NUM_DEV*BYTE_W-1:0] act_wr_timing,
  output logic [SETUP_W-1:0]        act_addr_setup
);
  logic unlock_done, relock_hit, commit_hit;
  logic [BYTE_W-1:0] reg_rdata;

  ide_win_unlock u_unlock (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_wide(acc_wide), .acc_offset(acc_offset), .acc_byte(acc_wdata[BYTE_W-1:0]),
    .ctrl_mode(ctrl_mode), .unlock_done(unlock_done), .relock_hit(relock_hit)
  );

  ide_win_regs #(.NUM_DEV(NUM_DEV)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(acc_valid && acc_write && ctrl_mode),
    .idx(acc_offset), .wdata(acc_wdata[BYTE_W-1:0]), .strap_q(clk_is_25),
    .rdata(reg_rdata), .commit_hit(commit_hit),
    .act_rd(act_rd_timing), .act_wr(act_wr_timing), .act_setup(act_addr_setup)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) clk_is_25 <= 1'b0;
    else        clk_is_25 <= strap_clk25;
  end

  assign tf_valid  = acc_valid && !ctrl_mode;
  assign tf_write  = acc_write;
  assign tf_wide   = acc_wide;
  assign tf_offset = acc_offset;
  assign tf_wdata  = acc_wdata;
  assign acc_rdata = ctrl_mode ? {{(BUS_W-BYTE_W){1'b0}}, reg_rdata} : tf_rdata;
endmodule

// File: rtl/ide_cfg_window_chk.sv
module ide_cfg_window_chk #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_valid,
  input logic          ctrl_mode,
  input logic          tf_valid,
  input logic          unlock_done,
  input logic          relock_hit,
  input logic          commit_hit,
  input logic [TW-1:0] act_rd_timing,
  input logic [TW-1:0] act_wr_timing,
  input logic [3:0]    act_addr_setup
);
  a_r1_unlock_enters: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_done |=> ctrl_mode);

  a_r1_mode_only_by_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_mode) |-> $past(unlock_done));

  a_r3_no_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && ctrl_mode) |-> !tf_valid);

  a_r4_relock_leaves: assert property (@(posedge clk) disable iff (!rst_n)
    relock_hit |=> !ctrl_mode);

  a_r7_hold_until_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_hit |=> ($stable(act_rd_timing) && $stable(act_wr_timing) &&
                     $stable(act_addr_setup)));

  a_r7_commit_in_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    commit_hit |-> ctrl_mode);
endmodule

bind ide_cfg_window ide_cfg_window_chk #(.TW(NUM_DEV*8)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .ctrl_mode(ctrl_mode),
  .tf_valid(tf_valid), .unlock_done(unlock_done), .relock_hit(relock_hit),
  .commit_hit(commit_hit), .act_rd_timing(act_rd_timing),
  .act_wr_timing(act_wr_timing), .act_addr_setup(act_addr_setup)
);

// File: tb/ide_cfg_window_test.sv
module ide_cfg_window_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_write = 1'b0, acc_wide = 1'b0;
  logic [2:0] acc_offset = '0;
  logic [15:0] acc_wdata = '0;
  logic [15:0] acc_rdata, tf_wdata, tf_rdata;
  logic tf_valid, tf_write, tf_wide, ctrl_mode, clk_is_25;
  logic [2:0] tf_offset;
  logic strap_clk25 = 1'b1;
  logic [15:0] act_rd_timing, act_wr_timing;
  logic [3:0] act_addr_setup;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] rd;
  logic fwd;

  always #10 clk = ~clk;

  assign tf_rdata = 16'hC300 | {13'd0, tf_offset};

  ide_cfg_window uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_wide(acc_wide), .acc_offset(acc_offset), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .tf_valid(tf_valid), .tf_write(tf_write),
    .tf_wide(tf_wide), .tf_offset(tf_offset), .tf_wdata(tf_wdata),
    .tf_rdata(tf_rdata), .strap_clk25(strap_clk25), .ctrl_mode(ctrl_mode),
    .clk_is_25(clk_is_25), .act_rd_timing(act_rd_timing),
    .act_wr_timing(act_wr_timing), .act_addr_setup(act_addr_setup)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One bus access; result and forward flag sampled mid-cycle.
  task automatic acc(logic wr, logic wide, logic [2:0] ofs, logic [15:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_wide = wide; acc_offset = ofs; acc_wdata = d;
    #5;
    rd = acc_rdata; fwd = tf_valid;
    @(posedge clk);
    #1 acc_valid = 1'b0;
  endtask

  task automatic do_key();
    acc(0, 1, 3'd1, 16'h0);
    acc(0, 1, 3'd1, 16'h0);
    acc(1, 0, 3'd2, 16'h0003);
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    chk("R10 mode", {15'd0, ctrl_mode}, 16'd0);
    chk("R10 act rd", act_rd_timing, 16'hFFFF);
    chk("R10 act wr", act_wr_timing, 16'hFFFF);
    chk("R10 setup", {12'd0, act_addr_setup}, 16'h000F);
    chk("R8 strap pin", {15'd0, clk_is_25}, 16'd1);
  endtask

  task automatic t_locked_pass();
    acc(0, 1, 3'd6, 16'h0);
    chk("R2 locked read data", rd, 16'hC306);
    chk("R2 locked forward", {15'd0, fwd}, 16'd1);
    acc(1, 0, 3'd2, 16'h0083);
    chk("R2 close key forwarded when locked", {15'd0, fwd}, 16'd1);
    chk("R2 still locked", {15'd0, ctrl_mode}, 16'd0);
  endtask

  task automatic t_bad_keys();
    acc(0, 1, 3'd1, 0); acc(0, 0, 3'd1, 0); acc(0, 1, 3'd1, 0); acc(1, 0, 3'd2, 16'h0003);
    chk("R2 byte read breaks key", {15'd0, ctrl_mode}, 16'd0);
    acc(0, 1, 3'd1, 0); acc(0, 1, 3'd1, 0); acc(1, 0, 3'd2, 16'h0004);
    chk("R2 wrong value breaks key", {15'd0, ctrl_mode}, 16'd0);
    acc(0, 1, 3'd1, 0); acc(0, 1, 3'd1, 0); acc(0, 1, 3'd1, 0); acc(1, 0, 3'd2, 16'h0003);
    chk("R2 third read breaks key", {15'd0, ctrl_mode}, 16'd0);
    acc(0, 1, 3'd1, 0); acc(0, 1, 3'd1, 0); acc(1, 1, 3'd2, 16'h0003);
    chk("R2 wide write breaks key", {15'd0, ctrl_mode}, 16'd0);
    chk("R2 key write forwarded", {15'd0, fwd}, 16'd1);
  endtask

  task automatic t_unlock();
    do_key();
    chk("R1 unlocked", {15'd0, ctrl_mode}, 16'd1);
    acc(0, 0, 3'd6, 0);
    chk("R10 selector reset value", rd, 16'h00F0);
    chk("R3 no forward in control mode", {15'd0, fwd}, 16'd0);
  endtask

  task automatic t_strap();
    strap_clk25 = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 pin 33MHz", {15'd0, clk_is_25}, 16'd0);
    acc(0, 0, 3'd5, 0);
    chk("R8 index5 33MHz", rd, 16'h0000);
    strap_clk25 = 1'b1;
    repeat (2) @(negedge clk);
    acc(1, 0, 3'd5, 16'h0000);
    acc(0, 0, 3'd5, 0);
    chk("R8 index5 25MHz, write ignored", rd, 16'h0001);
  endtask

  task automatic t_program();
    acc(1, 0, 3'd6, 16'h0030); acc(1, 0, 3'd0, 16'h0059); acc(1, 0, 3'd1, 16'h0046);
    acc(1, 0, 3'd6, 16'h0021); acc(1, 0, 3'd0, 16'h0020); acc(1, 0, 3'd1, 16'h0021);
    acc(0, 0, 3'd0, 0);
    chk("R6 dev1 read timing staged", rd, 16'h0020);
    acc(0, 0, 3'd6, 0);
    chk("R5 selector readback", rd, 16'h0021);
    acc(1, 0, 3'd6, 16'h0020);
    acc(0, 0, 3'd0, 0);
    chk("R6 dev0 read timing staged", rd, 16'h0059);
    acc(0, 0, 3'd1, 0);
    chk("R6 dev0 write timing staged", rd, 16'h0046);
    chk("R7 no effect before commit", act_rd_timing, 16'hFFFF);
    acc(1, 0, 3'd3, 16'h0084);
    chk("R7 wrong code no commit", act_wr_timing, 16'hFFFF);
    chk("R7 wrong code setup kept", {12'd0, act_addr_setup}, 16'h000F);
    acc(0, 0, 3'd3, 0);
    chk("R7 control reads back", rd, 16'h0084);
    acc(1, 0, 3'd6, 16'h0031);
    acc(1, 0, 3'd3, 16'h0085);
    chk("R7 commit read timings", act_rd_timing, 16'h2059);
    chk("R7 commit write timings", act_wr_timing, 16'h2146);
    chk("R5 commit setup code", {12'd0, act_addr_setup}, 16'h0003);
  endtask

  task automatic t_unimpl();
    acc(1, 0, 3'd4, 16'h0055); acc(1, 0, 3'd7, 16'h00AA); acc(1, 0, 3'd2, 16'h0011);
    acc(0, 0, 3'd4, 0); chk("R9 index4 reads zero", rd, 16'h0000);
    acc(0, 0, 3'd7, 0); chk("R9 index7 reads zero", rd, 16'h0000);
    acc(0, 0, 3'd2, 0); chk("R9 index2 reads zero", rd, 16'h0000);
    acc(0, 0, 3'd6, 0); chk("R9 selector untouched", rd, 16'h0031);
    acc(0, 0, 3'd0, 0); chk("R9 staged untouched", rd, 16'h0020);
    chk("R9 outputs untouched", act_rd_timing, 16'h2059);
  endtask

  task automatic t_relock();
    acc(1, 1, 3'd2, 16'h0083);
    chk("R4 wide close ignored", {15'd0, ctrl_mode}, 16'd1);
    acc(1, 0, 3'd2, 16'h0084);
    chk("R4 wrong close ignored", {15'd0, ctrl_mode}, 16'd1);
    acc(1, 0, 3'd2, 16'h0083);
    chk("R4 relocked", {15'd0, ctrl_mode}, 16'd0);
    acc(0, 1, 3'd0, 0);
    chk("R4 taskfile back", rd, 16'hC300);
    chk("R4 forward back", {15'd0, fwd}, 16'd1);
    chk("R7 timings kept after relock", act_wr_timing, 16'h2146);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_locked_pass();
    t_bad_keys();
    t_unlock();
    t_strap();
    t_program();
    t_unimpl();
    t_relock();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule